// File: doc/BRIEF.md
# Backup Power Switchover Controller

This block decides which source feeds a protected output rail, the main supply or a backup battery, and it drives an active-low power-fail warning. Its inputs are four comparator flags from the analog side, each asynchronous to the block clock: supply below the switchover threshold, supply below the battery, supply above the reset threshold, and monitored input below its reference. Its outputs are two switch enables, one for the main-supply path and one for the battery path. It also provides a mode status and a supply-good status that a separate reset generator uses to time its release.

Moving to the battery needs two conditions together: the supply must be below the switchover threshold and also below the battery. The move back to main supply depends only on the supply rising above the reset threshold, whatever the battery level. This gives a two-state hysteretic mode machine, `MODE_MAIN` and `MODE_BAT`. The transition `MAIN_TO_BAT` is taken on both low flags, and the transition `BAT_TO_MAIN` is taken on the above-reset flag. A second machine drives the switch enables from the mode. It has the states `SEQ_MAIN` (main path on), `SEQ_GAP` (both paths off) and `SEQ_BAT` (battery path on), so that every changeover passes through one clock with both paths open. The transitions are `MAIN_BREAK` (`SEQ_MAIN` to `SEQ_GAP` when the mode is battery), `GAP_MAKE_BAT` or `GAP_MAKE_MAIN` (leaving `SEQ_GAP` toward whichever path the mode selects in that cycle), and `BAT_BREAK` (`SEQ_BAT` to `SEQ_GAP` when the mode is main).

Top module: `swo_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, main_en=1, bat_en=0, on_battery=0, pf_n=1 and supply_good=0.
- R2: on_battery rises when both flags below_sw and below_bat are 1 after synchronisation. An input change made between clock edges first shows on on_battery after exactly SYNC_STAGES+1 rising edges.
- R3: While below_sw is 0, on_battery does not rise, whatever below_bat is. This covers a battery that is removed or reads low.
- R4: With below_sw at 1 and below_bat at 0, the rail stays on main supply. It moves to battery only once below_bat also becomes 1.
- R5: In battery mode, on_battery falls only when above_rst is 1. Clearing below_sw and below_bat alone leaves the rail on battery.
- R6: supply_good follows above_rst with the same latency as on_battery. On leaving battery mode, on_battery falls on the same edge on which supply_good rises.
- R7: pf_n is 0 when pfi_low or below_sw is 1 and is 1 otherwise, with a latency of SYNC_STAGES+1 rising edges.
- R8: main_en and bat_en are never both 1. After a change of on_battery, the old enable drops one edge later and the new enable rises one edge after that, which leaves exactly one cycle with both at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| below_sw_a | input | 1 | Supply below the switchover threshold (asynchronous) |
| below_bat_a | input | 1 | Supply below the battery voltage (asynchronous) |
| above_rst_a | input | 1 | Supply above the reset threshold (asynchronous) |
| pfi_low_a | input | 1 | Monitored input below its reference (asynchronous) |
| main_en | output | 1 | Enable for the main-supply switch |
| bat_en | output | 1 | Enable for the battery switch |
| pf_n | output | 1 | Power-fail warning, active low |
| on_battery | output | 1 | Mode status, 1 in battery mode |
| supply_good | output | 1 | Synchronised above-reset status for the reset generator |

## Verification
The bench uses the default SYNC_STAGES of 2. At that depth the full chain is five edges long: the synchroniser, the mode register, the break step and the make step. This keeps a single changeover short, so both directed edge-by-edge timing checks and thousands of random flag changes fit within a few thousand cycles. Random flag changes that last only one or two cycles reach the case where the mode reverses while the sequencer is in its gap state.

// File: rtl/swo_pkg.sv
package swo_pkg;
    localparam int NFLAG         = 4;
    localparam int FLG_BELOW_SW  = 0;
    localparam int FLG_BELOW_BAT = 1;
    localparam int FLG_ABOVE_RST = 2;
    localparam int FLG_PFI_LOW   = 3;

    typedef enum logic {
        MODE_MAIN = 1'b0,
        MODE_BAT  = 1'b1
    } mode_e;

    typedef enum logic [1:0] {
        SEQ_MAIN = 2'd0,
        SEQ_GAP  = 2'd1,
        SEQ_BAT  = 2'd2
    } seq_e;
endpackage

// File: rtl/swo_sync.sv
module swo_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_a,
    output logic [WIDTH-1:0] q
);
    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] stage_q [STAGES];

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            if (gi == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[gi] <= '0;
                    else        stage_q[gi] <= d_a;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[gi] <= '0;
                    else        stage_q[gi] <= stage_q[gi-1];
                end
            end
        end
    endgenerate

    assign q = stage_q[LAST];
endmodule

// File: rtl/swo_mode_fsm.sv
module swo_mode_fsm
    import swo_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFLAG-1:0] flag_s,
    output logic             on_battery,
    output logic             pf_n,
    output logic             supply_good
);
    mode_e mode_q, mode_d;

    logic enter_bat;
    logic leave_bat;

    assign enter_bat = flag_s[FLG_BELOW_SW] & flag_s[FLG_BELOW_BAT];
    assign leave_bat = flag_s[FLG_ABOVE_RST];

    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_MAIN: if (enter_bat) mode_d = MODE_BAT;   // MAIN_TO_BAT
            MODE_BAT:  if (leave_bat) mode_d = MODE_MAIN;  // BAT_TO_MAIN
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= MODE_MAIN;
        else        mode_q <= mode_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pf_n        <= 1'b1;
            supply_good <= 1'b0;
        end else begin
            pf_n        <= ~(flag_s[FLG_PFI_LOW] | flag_s[FLG_BELOW_SW]);
            supply_good <= flag_s[FLG_ABOVE_RST];
        end
    end

    assign on_battery = (mode_q == MODE_BAT);
endmodule

// File: rtl/swo_switch_seq.sv
module swo_switch_seq
    import swo_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic want_bat,
    output logic main_en,
    output logic bat_en
);
    seq_e seq_q, seq_d;

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q)
            SEQ_MAIN: if (want_bat)  seq_d = SEQ_GAP;        // MAIN_BREAK
            SEQ_GAP:  seq_d = want_bat ? SEQ_BAT : SEQ_MAIN; // GAP_MAKE_*
            SEQ_BAT:  if (!want_bat) seq_d = SEQ_GAP;        // BAT_BREAK
            default:  seq_d = SEQ_GAP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= SEQ_MAIN;
        else        seq_q <= seq_d;
    end

    always_comb begin
        main_en = 1'b0;
        bat_en  = 1'b0;
        unique case (seq_q)
            SEQ_MAIN: main_en = 1'b1;
            SEQ_GAP:  ;
            SEQ_BAT:  bat_en  = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/swo_ctrl.sv
module swo_ctrl
    import swo_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic below_sw_a,
    input  logic below_bat_a,
    input  logic above_rst_a,
    input  logic pfi_low_a,
    output logic main_en,
    output logic bat_en,
    output logic pf_n,
    output logic on_battery,
    output logic supply_good
);
    logic [NFLAG-1:0] flag_a;
    logic [NFLAG-1:0] flag_s;

    always_comb begin
        flag_a                = '0;
        flag_a[FLG_BELOW_SW]  = below_sw_a;
        flag_a[FLG_BELOW_BAT] = below_bat_a;
        flag_a[FLG_ABOVE_RST] = above_rst_a;
        flag_a[FLG_PFI_LOW]   = pfi_low_a;
    end

    swo_sync #(.WIDTH(NFLAG), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_a   (flag_a),
        .q     (flag_s)
    );

    swo_mode_fsm u_mode (
        .clk         (clk),
        .rst_n       (rst_n),
        .flag_s      (flag_s),
        .on_battery  (on_battery),
        .pf_n        (pf_n),
        .supply_good (supply_good)
    );

    swo_switch_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .want_bat (on_battery),
        .main_en  (main_en),
        .bat_en   (bat_en)
    );
endmodule

// File: rtl/swo_ctrl_chk.sv
module swo_ctrl_chk
    import swo_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             main_en,
    input logic             bat_en,
    input logic             pf_n,
    input logic             on_battery,
    input logic             supply_good,
    input logic [NFLAG-1:0] flag_s
);
    p_enter_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(on_battery) |-> $past(flag_s[FLG_BELOW_SW] && flag_s[FLG_BELOW_BAT]));

    p_hold_main_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!on_battery && !flag_s[FLG_BELOW_SW]) |=> !on_battery);

    p_hold_main_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!on_battery && !flag_s[FLG_BELOW_BAT]) |=> !on_battery);

    p_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(on_battery) |-> $past(flag_s[FLG_ABOVE_RST]));

    p_exit_with_good_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(on_battery) |-> supply_good);

    p_pf_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_s[FLG_PFI_LOW] || flag_s[FLG_BELOW_SW]) |=> !pf_n);

    p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(main_en && bat_en));

    p_bat_make_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bat_en) |-> $past(!main_en));

    p_main_make_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(main_en) |-> $past(!bat_en));

    p_break_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(on_battery) |=> !main_en);
endmodule

bind swo_ctrl swo_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .main_en     (main_en),
    .bat_en      (bat_en),
    .pf_n        (pf_n),
    .on_battery  (on_battery),
    .supply_good (supply_good),
    .flag_s      (flag_s)
);

// File: tb/swo_ctrl_tb.sv
`timescale 1ns/1ps
module swo_ctrl_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic below_sw_a = 1'b0, below_bat_a = 1'b0, above_rst_a = 1'b0, pfi_low_a = 1'b0;
    logic main_en, bat_en, pf_n, on_battery, supply_good;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit model_on = 1'b0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    swo_ctrl #(.SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .below_sw_a(below_sw_a), .below_bat_a(below_bat_a),
        .above_rst_a(above_rst_a), .pfi_low_a(pfi_low_a),
        .main_en(main_en), .bat_en(bat_en), .pf_n(pf_n),
        .on_battery(on_battery), .supply_good(supply_good)
    );

    // Reference model, built from the requirements.
    // Flag vector order: {pfi_low, above_rst, below_bat, below_sw}
    logic [3:0] m_s1, m_s2;
    logic       m_bat, m_pf_n, m_good;
    logic [1:0] m_seq; // 0 main on, 1 both off, 2 battery on

    function automatic logic f_next_mode(logic bat, logic [3:0] f);
        if (!bat) return f[0] & f[1];
        else      return ~f[2];
    endfunction

    function automatic logic [1:0] f_next_seq(logic [1:0] s, logic want_bat);
        case (s)
            2'd0:    return want_bat ? 2'd1 : 2'd0;
            2'd2:    return want_bat ? 2'd2 : 2'd1;
            default: return want_bat ? 2'd2 : 2'd0;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 <= '0; m_s2 <= '0; m_bat <= 1'b0;
            m_pf_n <= 1'b1; m_good <= 1'b0; m_seq <= 2'd0;
        end else begin
            m_s1   <= {pfi_low_a, above_rst_a, below_bat_a, below_sw_a};
            m_s2   <= m_s1;
            m_bat  <= f_next_mode(m_bat, m_s2);
            m_pf_n <= ~(m_s2[3] | m_s2[0]);
            m_good <= m_s2[2];
            m_seq  <= f_next_seq(m_seq, m_bat);
        end
    end

    task automatic chk(string req, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b at cycle %0d", req, what, act, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (model_on && rst_n) begin
            chk("R2", "on_battery", on_battery, m_bat);
            chk("R6", "supply_good", supply_good, m_good);
            chk("R7", "pf_n", pf_n, m_pf_n);
            chk("R8", "main_en", main_en, m_seq == 2'd0);
            chk("R8", "bat_en", bat_en, m_seq == 2'd2);
        end
    end

    task automatic finish_report();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        if (cycles > 100000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            finish_report();
        end
    end

    task automatic wait_edges(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drive(logic sw, logic bt, logic rs, logic pf);
        below_sw_a = sw; below_bat_a = bt; above_rst_a = rs; pfi_low_a = pf;
    endtask

    initial begin
        void'($urandom(32'h5eed_0101));
        wait_edges(3);
        chk("R1", "main_en in reset", main_en, 1'b1);
        chk("R1", "bat_en in reset", bat_en, 1'b0);
        chk("R1", "on_battery in reset", on_battery, 1'b0);
        chk("R1", "pf_n in reset", pf_n, 1'b1);
        chk("R1", "supply_good in reset", supply_good, 1'b0);
        rst_n = 1'b1;
        wait_edges(1);
        chk("R1", "main_en after reset", main_en, 1'b1);
        chk("R1", "supply_good after reset", supply_good, 1'b0);
        model_on = 1'b1;

        // Supply healthy
        drive(1'b0, 1'b0, 1'b1, 1'b0);
        wait_edges(6);
        chk("R6", "supply_good healthy", supply_good, 1'b1);

        // R3: below battery only, or battery removed: stays on main
        drive(1'b0, 1'b1, 1'b0, 1'b0);
        wait_edges(10);
        chk("R3", "on_battery below_bat only", on_battery, 1'b0);
        chk("R3", "main_en below_bat only", main_en, 1'b1);
        chk("R7", "pf_n with no fail flags", pf_n, 1'b1);

        // R4: below switch threshold but above battery: stays main
        drive(1'b1, 1'b0, 1'b0, 1'b0);
        wait_edges(10);
        chk("R4", "on_battery below_sw only", on_battery, 1'b0);
        chk("R4", "main_en below_sw only", main_en, 1'b1);
        chk("R7", "pf_n low from below_sw", pf_n, 1'b0);

        // R2: battery now above supply, exact latency
        drive(1'b1, 1'b1, 1'b0, 1'b0);
        wait_edges(2);
        chk("R2", "on_battery after 2 edges", on_battery, 1'b0);
        wait_edges(1);
        chk("R2", "on_battery after 3 edges", on_battery, 1'b1);
        chk("R8", "main_en still on at 3 edges", main_en, 1'b1);
        wait_edges(1);
        chk("R8", "main_en gap at 4 edges", main_en, 1'b0);
        chk("R8", "bat_en gap at 4 edges", bat_en, 1'b0);
        wait_edges(1);
        chk("R8", "bat_en made at 5 edges", bat_en, 1'b1);

        // R5: flags clear but no above-reset: stay on battery
        drive(1'b0, 1'b0, 1'b0, 1'b0);
        wait_edges(10);
        chk("R5", "on_battery held without above_rst", on_battery, 1'b1);
        chk("R5", "bat_en held without above_rst", bat_en, 1'b1);

        // R5/R6: above reset returns to main with supply_good together
        drive(1'b0, 1'b1, 1'b1, 1'b0);
        wait_edges(2);
        chk("R6", "supply_good after 2 edges", supply_good, 1'b0);
        chk("R5", "on_battery after 2 edges", on_battery, 1'b1);
        wait_edges(1);
        chk("R6", "supply_good after 3 edges", supply_good, 1'b1);
        chk("R5", "on_battery returns regardless of battery", on_battery, 1'b0);
        wait_edges(1);
        chk("R8", "bat_en break", bat_en, 1'b0);
        chk("R8", "main_en gap", main_en, 1'b0);
        wait_edges(1);
        chk("R8", "main_en made", main_en, 1'b1);

        // R7: monitored input low with supply fine
        drive(1'b0, 1'b0, 1'b1, 1'b1);
        wait_edges(2);
        chk("R7", "pf_n after 2 edges", pf_n, 1'b1);
        wait_edges(1);
        chk("R7", "pf_n after 3 edges", pf_n, 1'b0);
        drive(1'b0, 1'b0, 1'b1, 1'b0);
        wait_edges(3);
        chk("R7", "pf_n recovers", pf_n, 1'b1);

        // Random phase, checked each cycle by the model
        for (int i = 0; i < 1500; i++) begin
            logic [3:0] r;
            r = 4'($urandom());
            drive(r[0], r[1], r[2], r[3]);
            wait_edges(int'($urandom_range(1, 10)));
        end

        // Mid-reset: back to reset state
        rst_n = 1'b0;
        wait_edges(1);
        chk("R1", "main_en in second reset", main_en, 1'b1);
        chk("R1", "on_battery in second reset", on_battery, 1'b0);
        chk("R1", "pf_n in second reset", pf_n, 1'b1);
        finish_report();
    end
endmodule